// File: doc/BRIEF.md
# Serially Programmable Slot Module Selector

This block sits beside one slot of a reconfigurable region and decides whether the module placed there answers the current bus access. It does not compare the address against a fixed value. Instead it holds a small lookup table with one entry per value of the module field of the bus address, and uses the entry picked by that field as the hit signal. The table is loaded one bit at a time through a configuration bit and shift strobe, so the module's address can be set, moved or duplicated while the rest of the system runs.

A freshly placed slot starts with every table entry set to one. That pattern means "not configured yet": it holds the module in reset and answers no access. System logic then shifts in the real pattern. A single one at entry N gives the module address N. Several ones let one module answer several addresses, for a multicast write whose read data the system merges by OR. The highest field value is reserved for "no module selected", and it never produces a select. The low bits of the bus address pass through unchanged as the index into the module's own registers.

Top module: `slot_sel_decoder`

## Requirements
- R1: While `rst` is high at a rising clock edge, every table entry is set to one. After that edge `mod_rst` is 1 and `mod_sel` is 0.
- R2: On each rising edge with `cfg_shift` high, the table shifts one place toward entry 0 and `cfg_bit` enters the top entry. In a burst of 16 shifts, the bit sent k-th (k = 0..15) ends up at entry k. With `cfg_shift` low, the table holds its value.
- R3: `mod_rst` is 1 exactly when every table entry is one. It goes to 0 as soon as any zero is in the table.
- R4: The module field is `bus_addr[11:8]`. `mod_sel` is combinational and equals 1 when `bus_en` is 1 and the table entry indexed by that field is 1, unless R5, R7 or R11 block it.
- R5: The field value 4'hF never asserts `mod_sel`, even when entry 15 of the table is 1.
- R6: `mod_rd` is 1 only when `mod_sel` and `bus_rd` are both 1.
- R7: `mod_sel` is 0 while a shift is in progress. A shift is in progress when `cfg_shift` is high, or when a burst has started but fewer than 16 bits have been shifted since reset or since the last complete burst.
- R8: A table with several ones gives `mod_sel` for each of those field values.
- R9: `mod_reg_idx` always equals `bus_addr[7:0]`.
- R10: `mod_sel` is 0 whenever `bus_en` is 0.
- R11: While `mod_rst` is 1, `mod_sel` is 0 for every field value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the table and the burst counter change on its rising edge |
| rst | input | 1 | Synchronous active-high reset; fills the table with ones |
| bus_addr | input | 12 | Bus address; bits 11:8 are the module field, bits 7:0 the register index |
| bus_en | input | 1 | Bus access valid |
| bus_rd | input | 1 | Access is a read |
| cfg_shift | input | 1 | Shift strobe for the table |
| cfg_bit | input | 1 | Serial table data bit |
| mod_sel | output | 1 | Module selected for this access |
| mod_rd | output | 1 | Module selected for a read |
| mod_rst | output | 1 | Module held in reset (table not configured) |
| mod_reg_idx | output | 8 | Register index into the module |

## Verification
The bench builds the block with its defaults: a 4-bit module field and an 8-bit register index, which give a 16-entry table and a 16-shift burst. These defaults make every field value reachable, including the reserved top value, and they keep each burst short. So the bench can load a table with several ones that also has entry 15 set, then sweep both hits and misses through its vector table. The same short burst lets it stop halfway through a load to show that selects stay off, and lets it shift in an all-ones pattern to show that the module stays in reset.

// File: rtl/slot_sel_pkg.sv
package slot_sel_pkg;

    // Load state of the serial table
    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_BURST = 1'b1
    } load_phase_e;

    // True when a field value is the reserved "nobody" code (all ones)
    function automatic logic field_is_reserved(input logic [31:0] field, input int unsigned width);
        logic [31:0] top;
        top = (32'd1 << width) - 32'd1;
        return (field == top);
    endfunction

endpackage

// File: rtl/sel_table_shift.sv
module sel_table_shift
    import slot_sel_pkg::*;
#(
    parameter int SEL_W = 4,
    localparam int DEPTH = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_shift,
    input  logic             cfg_bit,
    output logic [DEPTH-1:0] table_q,
    output logic             busy,
    output logic             unconfigured
);

    logic [SEL_W-1:0] shift_cnt;
    load_phase_e      phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            table_q   <= '1;
            shift_cnt <= '0;
        end else if (cfg_shift) begin
            table_q   <= {cfg_bit, table_q[DEPTH-1:1]};
            shift_cnt <= shift_cnt + {{(SEL_W-1){1'b0}}, 1'b1};
        end
    end

    assign phase        = (shift_cnt != '0) ? PH_BURST : PH_IDLE;
    assign busy         = cfg_shift || (phase == PH_BURST);
    assign unconfigured = &table_q;

    // R1: reset fills the table with ones
    p_reset_fill_r1: assert property (@(posedge clk) rst |=> (&table_q));

    // R2: a shift loads the serial bit into the top entry
    p_shift_in_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_shift |=> (table_q[DEPTH-1] == $past(cfg_bit)));

    // R2: no shift strobe, table keeps its contents
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !cfg_shift |=> $stable(table_q));

endmodule

// File: rtl/sel_lookup.sv
module sel_lookup
    import slot_sel_pkg::*;
#(
    parameter int SEL_W = 4,
    localparam int DEPTH = 1 << SEL_W
) (
    input  logic [DEPTH-1:0] table_q,
    input  logic [SEL_W-1:0] field,
    input  logic             bus_en,
    input  logic             bus_rd,
    input  logic             blocked,
    output logic             sel,
    output logic             rd
);

    logic [DEPTH-1:0] hit;

    // One hit term per table entry; the reserved top code never hits
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        localparam logic IS_RSV = (i == DEPTH - 1);
        assign hit[i] = table_q[i] && (field == SEL_W'(i)) && !IS_RSV;
    end

    assign sel = bus_en && !blocked && (|hit);
    assign rd  = sel && bus_rd;

    // R5: hit vector never selects through the reserved code
    always_comb begin
        if (field_is_reserved(32'(field), SEL_W))
            a_rsv_no_hit_r5: assert (hit == '0);
    end

endmodule

// File: rtl/slot_sel_decoder.sv
module slot_sel_decoder
    import slot_sel_pkg::*;
#(
    parameter int SEL_W = 4,
    parameter int IDX_W = 8,
    localparam int ADDR_W = SEL_W + IDX_W,
    localparam int DEPTH  = 1 << SEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_en,
    input  logic              bus_rd,
    input  logic              cfg_shift,
    input  logic              cfg_bit,
    output logic              mod_sel,
    output logic              mod_rd,
    output logic              mod_rst,
    output logic [IDX_W-1:0]  mod_reg_idx
);

    logic [DEPTH-1:0] table_q;
    logic             busy;
    logic             unconfigured;
    logic [SEL_W-1:0] field;

    assign field       = bus_addr[IDX_W +: SEL_W];
    assign mod_reg_idx = bus_addr[IDX_W-1:0];
    assign mod_rst     = unconfigured;

    sel_table_shift #(.SEL_W(SEL_W)) u_table (
        .clk          (clk),
        .rst          (rst),
        .cfg_shift    (cfg_shift),
        .cfg_bit      (cfg_bit),
        .table_q      (table_q),
        .busy         (busy),
        .unconfigured (unconfigured)
    );

    sel_lookup #(.SEL_W(SEL_W)) u_lookup (
        .table_q (table_q),
        .field   (field),
        .bus_en  (bus_en),
        .bus_rd  (bus_rd),
        .blocked (busy || unconfigured),
        .sel     (mod_sel),
        .rd      (mod_rd)
    );

    // R10: no select without a bus access
    p_sel_needs_en_r10: assert property (@(posedge clk) disable iff (rst)
        mod_sel |-> bus_en);

    // R6: a read strobe needs both select and a read access
    p_rd_needs_sel_r6: assert property (@(posedge clk) disable iff (rst)
        mod_rd |-> (mod_sel && bus_rd));

    // R5: reserved field value never selects
    p_no_sel_reserved_r5: assert property (@(posedge clk) disable iff (rst)
        (field == '1) |-> !mod_sel);

    // R7: no select while a load burst is open
    p_no_sel_busy_r7: assert property (@(posedge clk) disable iff (rst)
        cfg_shift |-> !mod_sel);

    // R11: module held in reset never sees a select
    p_no_sel_in_reset_r11: assert property (@(posedge clk) disable iff (rst)
        mod_rst |-> !mod_sel);

endmodule

// File: tb/slot_sel_decoder_tb.sv
`timescale 1ns/100ps
module slot_sel_decoder_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_en = 1'b0;
    logic        bus_rd = 1'b0;
    logic        cfg_shift = 1'b0;
    logic        cfg_bit = 1'b0;
    logic        mod_sel, mod_rd, mod_rst;
    logic [7:0]  mod_reg_idx;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    slot_sel_decoder u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_en(bus_en),
        .bus_rd(bus_rd), .cfg_shift(cfg_shift), .cfg_bit(cfg_bit),
        .mod_sel(mod_sel), .mod_rd(mod_rd), .mod_rst(mod_rst),
        .mod_reg_idx(mod_reg_idx)
    );

    // Vector: [15:12] field, [11:4] reg index, [3] en, [2] rd, [1] exp sel, [0] exp rd
    // Table loaded beforehand: entries 5, 9 and 15 set
    localparam logic [15:0] VEC [10] = '{
        {4'h5, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0},   // R4 hit, write
        {4'h5, 8'h3C, 1'b1, 1'b1, 1'b1, 1'b1},   // R6 hit, read
        {4'h9, 8'hA5, 1'b1, 1'b1, 1'b1, 1'b1},   // R8 second address
        {4'h9, 8'h11, 1'b1, 1'b0, 1'b1, 1'b0},   // R8 write multicast
        {4'h3, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0},   // R4 miss
        {4'hF, 8'h42, 1'b1, 1'b1, 1'b0, 1'b0},   // R5 reserved code
        {4'h5, 8'h07, 1'b0, 1'b1, 1'b0, 1'b0},   // R10 no bus access
        {4'h0, 8'h80, 1'b1, 1'b0, 1'b0, 1'b0},   // R4 miss at entry 0
        {4'hA, 8'h5A, 1'b1, 1'b1, 1'b0, 1'b0},   // R4 miss next to 9
        {4'h4, 8'h01, 1'b1, 1'b1, 1'b0, 1'b0}    // R4 miss next to 5
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Shift n bits of pat, bit k sent k-th; inputs change on falling edges
    task automatic shift_bits(input logic [15:0] pat, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cfg_shift = 1'b1;
            cfg_bit   = pat[k];
        end
        @(negedge clk);
        cfg_shift = 1'b0;
        cfg_bit   = 1'b0;
    endtask

    task automatic access(input logic [3:0] f, input logic [7:0] idx, input logic en, input logic rd);
        bus_addr = {f, idx};
        bus_en   = en;
        bus_rd   = rd;
        #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 / R11: reset state, unconfigured module answers nothing
        access(4'h5, 8'h00, 1'b1, 1'b1);
        check("R1 mod_rst after reset", {7'd0, mod_rst}, 8'd1);
        check("R11 sel blocked in reset", {7'd0, mod_sel}, 8'd0);
        access(4'h0, 8'h00, 1'b1, 1'b0);
        check("R11 sel blocked entry 0", {7'd0, mod_sel}, 8'd0);

        // R3: shifting all ones keeps the module in reset
        shift_bits(16'hFFFF, 16);
        access(4'h2, 8'h00, 1'b1, 1'b0);
        check("R3 all ones keeps reset", {7'd0, mod_rst}, 8'd1);

        // R2 / R8: load entries 5, 9 and 15
        shift_bits(16'h8220, 16);
        access(4'h5, 8'h00, 1'b0, 1'b0);
        check("R3 reset released", {7'd0, mod_rst}, 8'd0);

        foreach (VEC[i]) begin
            logic [15:0] v;
            v = VEC[i];
            @(negedge clk);
            access(v[15:12], v[11:4], v[3], v[2]);
            check("R4/R5/R8/R10 vector sel", {7'd0, mod_sel}, {7'd0, v[1]});
            check("R6 vector rd", {7'd0, mod_rd}, {7'd0, v[0]});
            check("R9 reg index", mod_reg_idx, v[11:4]);
        end

        // R7: select held off during a strobe and a half-done burst
        @(negedge clk);
        cfg_shift = 1'b1;
        cfg_bit   = 1'b0;
        access(4'h5, 8'h00, 1'b1, 1'b0);
        check("R7 sel off while strobing", {7'd0, mod_sel}, 8'd0);
        @(negedge clk);
        cfg_shift = 1'b0;
        // one bit shifted: table now entries 4, 8, 14 set; burst open
        access(4'h4, 8'h00, 1'b1, 1'b0);
        check("R7 sel off mid burst", {7'd0, mod_sel}, 8'd0);
        // finish the burst with remaining 15 bits of pattern for address 2
        shift_bits(16'h0002, 15);
        // first bit was 0 so full load = 16'h0004 >> ... : entry k = k-th bit sent
        // sent bits: 0, then pat[0..14] of 16'h0002 -> bit 2 set at entry 2
        access(4'h2, 8'h00, 1'b1, 1'b1);
        check("R2 bit order entry 2", {7'd0, mod_sel}, 8'd1);
        check("R6 read after reload", {7'd0, mod_rd}, 8'd1);
        access(4'h1, 8'h00, 1'b1, 1'b1);
        check("R2 neighbour entry 1 clear", {7'd0, mod_sel}, 8'd0);
        access(4'h5, 8'h00, 1'b1, 1'b0);
        check("R2 old address 5 gone", {7'd0, mod_sel}, 8'd0);

        // R1: reset returns to unconfigured
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        access(4'h2, 8'h00, 1'b1, 1'b0);
        check("R1 reset refills table", {7'd0, mod_rst}, 8'd1);
        check("R11 sel off after refill", {7'd0, mod_sel}, 8'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule